// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter. The comparator, the DAC (capacitor array or resistor ladder) and the track/hold switches are outside the block. When a start request arrives, the sequencer keeps both input switches in track for a programmable number of clock cycles so the sampling capacitor can charge. It then opens them into hold and runs a binary search on the DAC code, one bit per step from the most significant bit down.

Each step sets the bit under test, waits a programmable settle time, and then samples the comparator to decide whether the bit stays. After the last step the final code is copied to the result register, a one-cycle done pulse is raised, and the switches return to track with the DAC code at zero. While a conversion is in progress, further start requests are dropped. The result stays unchanged until the next conversion finishes.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset both switch outputs are 1 (track), the DAC code is 0, the result is 0 and done is 0.
- R2: The two switch outputs always carry the same value. The value is 1 (track) while idle or acquiring and 0 (hold) during the search.
- R3: Acquisition lasts max(acq_len_i, 1) cycles, counted from the clock edge that accepts the start. A length of 0 behaves as 1.
- R4: Whenever the switches are in track, the DAC code is 0.
- R5: In the first hold cycle the DAC code is 0x800 (only bit 11 set). Each step lasts max(settle_len_i, 1) cycles. At the end of a step the bit under test is cleared if cmp_i is 1, which means the DAC is above the held input, and kept if cmp_i is 0. The next lower bit is then set for the following step.
- R6: After 12 steps the result equals the final code. With an ideal comparator this is the held input code.
- R7: Done is high for exactly one cycle. It goes high max(A,1) + 12*max(S,1) cycles after the edge that accepted the start.
- R8: A start request seen while acquisition or search is running is ignored. It does not change the timing or the result and does not produce an extra done.
- R9: The result register changes only in the cycle in which done is high.
- R10: The comparator value is used only on the last cycle of each settle step. Its value in earlier cycles of the step has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, accepted only when idle |
| acq_len_i | input | CNT_W | Acquisition length in cycles (0 treated as 1) |
| settle_len_i | input | CNT_W | Settle cycles per search step (0 treated as 1) |
| cmp_i | input | 1 | Comparator: 1 = DAC above held input |
| sw_in_trk_o | output | 1 | Input switch control, 1 = track, 0 = hold |
| sw_node_trk_o | output | 1 | Summing-node switch control, 1 = track, 0 = hold |
| dac_o | output | RES | DAC code under test |
| result_o | output | RES | Latched conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check several structural properties. The two switch outputs must agree. The DAC code must be zero while tracking, and the search must open at the MSB code. Done must be a single-cycle pulse that follows the final step, the result must stay frozen outside done, and a start that arrives while busy must not be taken. Other behaviour can only be shown by the bench scenarios. These cover the exact acquisition and step lengths, including zero lengths treated as one, and correct codes across the full range. They also cover comparator values that are wrong early in a settle step being ignored, and a start pulse injected mid-search changing neither the latency nor the number of done pulses.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } sar_phase_e;

  // Switches track in every phase except the search.
  function automatic logic phase_tracks(input sar_phase_e p);
    return p != PH_CONV;
  endfunction

endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  // A zero length is promoted to one cycle.
  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= eff_len(len_i);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic           decide_i,
  input  logic           cmp_i,
  output logic [RES-1:0] code_o,
  output logic [RES-1:0] resolved_o,
  output logic           last_o
);

  localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [RES-1:0] MSB_CODE = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0]   code_q;
  logic [IDX_W-1:0] idx_q;

  // Keep or drop the bit under test depending on the comparator.
  function automatic logic [RES-1:0] resolve(input logic [RES-1:0] c,
                                             input logic [IDX_W-1:0] i,
                                             input logic above);
    logic [RES-1:0] r;
    r = c;
    if (above) r[i] = 1'b0;
    return r;
  endfunction

  // Tentatively set the next lower bit.
  function automatic logic [RES-1:0] advance(input logic [RES-1:0] c,
                                             input logic [IDX_W-1:0] i);
    logic [RES-1:0] r;
    r = c;
    if (i != '0) r[i - 1'b1] = 1'b1;
    return r;
  endfunction

  assign resolved_o = resolve(code_q, idx_q, cmp_i);
  assign last_o     = (idx_q == '0);
  assign code_o     = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
    end else if (init_i) begin
      code_q <= MSB_CODE;
      idx_q  <= IDX_W'(RES - 1);
    end else if (decide_i) begin
      if (last_o) begin
        code_q <= '0;
      end else begin
        code_q <= advance(resolved_o, idx_q);
        idx_q  <= idx_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int RES   = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] acq_len_i,
  input  logic [CNT_W-1:0] settle_len_i,
  input  logic             cmp_i,
  output logic             sw_in_trk_o,
  output logic             sw_node_trk_o,
  output logic [RES-1:0]   dac_o,
  output logic [RES-1:0]   result_o,
  output logic             done_o
);
  import sar_pkg::*;

  sar_phase_e       phase_q, phase_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_exp;

  // Named internal events, visible to the checker.
  logic             busy_w;
  logic             start_taken;
  logic             acq_end;
  logic             step_end;
  logic             conv_end;
  logic             last_bit;
  logic [RES-1:0]   code_w;
  logic [RES-1:0]   resolved_w;

  assign busy_w      = (phase_q != PH_IDLE);
  assign start_taken = start_i && !busy_w;
  assign acq_end     = (phase_q == PH_ACQ)  && tmr_exp;
  assign step_end    = (phase_q == PH_CONV) && tmr_exp;
  assign conv_end    = step_end && last_bit;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_len  = acq_len_i;
    if (start_taken) begin
      phase_d  = PH_ACQ;
      tmr_load = 1'b1;
    end
    if (acq_end) begin
      phase_d  = PH_CONV;
      tmr_load = 1'b1;
      tmr_len  = settle_len_i;
    end
    if (step_end) begin
      tmr_len = settle_len_i;
      if (last_bit) phase_d  = PH_IDLE;
      else          tmr_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_o  <= conv_end;
      if (conv_end) result_o <= resolved_w;
    end
  end

  sar_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_exp)
  );

  sar_search #(.RES(RES)) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (acq_end),
    .decide_i   (step_end),
    .cmp_i      (cmp_i),
    .code_o     (code_w),
    .resolved_o (resolved_w),
    .last_o     (last_bit)
  );

  assign sw_in_trk_o   = phase_tracks(phase_q);
  assign sw_node_trk_o = phase_tracks(phase_q);
  assign dac_o         = code_w;

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           sw_in_trk_o,
  input logic           sw_node_trk_o,
  input logic [RES-1:0] dac_o,
  input logic [RES-1:0] result_o,
  input logic           done_o,
  input logic           busy_w,
  input logic           start_taken,
  input logic           conv_end
);

  localparam logic [RES-1:0] MSB_CODE = {1'b1, {(RES-1){1'b0}}};

  AST_SW_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_in_trk_o == sw_node_trk_o);  // R2

  AST_TRACK_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sw_in_trk_o |-> (dac_o == '0));  // R4

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_in_trk_o) |-> (dac_o == MSB_CODE));  // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> done_o);  // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start_i) |-> !start_taken);  // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));  // R9

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES(RES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .sw_in_trk_o   (sw_in_trk_o),
  .sw_node_trk_o (sw_node_trk_o),
  .dac_o         (dac_o),
  .result_o      (result_o),
  .done_o        (done_o),
  .busy_w        (busy_w),
  .start_taken   (start_taken),
  .conv_end      (conv_end)
);

// File: tb/sim_sar_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sar_seq_ctrl;

  localparam int RES   = 12;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] acq_len_i = '0;
  logic [CNT_W-1:0] settle_len_i = '0;
  logic             cmp_i;
  logic             sw_in_trk_o, sw_node_trk_o, done_o;
  logic [RES-1:0]   dac_o, result_o;

  always #4 clk = ~clk;  // 125 MHz

  sar_seq_ctrl #(.RES(RES), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .acq_len_i(acq_len_i),
    .settle_len_i(settle_len_i), .cmp_i(cmp_i), .sw_in_trk_o(sw_in_trk_o),
    .sw_node_trk_o(sw_node_trk_o), .dac_o(dac_o), .result_o(result_o),
    .done_o(done_o)
  );

  typedef struct {
    logic [RES-1:0] code;
    int             t0;
    int             lat;
  } exp_t;

  exp_t           exp_q[$];
  int             nchk = 0;
  int             nfail = 0;
  int             cyc = 0;
  logic [RES-1:0] vin = '0;
  int             settle_eff = 1;
  logic [RES-1:0] prev_res = '0;
  bit             chk_after = 0;
  int             age = 0;
  logic [RES-1:0] last_dac = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Comparator model: reports the wrong side until the last settle cycle (R10).
  always @(negedge clk) begin
    if (dac_o != last_dac) age <= 0;
    else if (age < 1000)   age <= age + 1;
    last_dac <= dac_o;
  end
  assign cmp_i = (age >= settle_eff - 1) ? (dac_o > vin) : !(dac_o > vin);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops expected items as done pulses appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_after) begin
        check(!done_o, "R7 done single cycle", int'(done_o), 0);
        check(result_o == prev_res, "R9 result held after done", int'(result_o), int'(prev_res));
        chk_after = 0;
      end
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(result_o == it.code, "R6 R10 result code", int'(result_o), int'(it.code));
          check((cyc - it.t0) == it.lat, "R7 R3 latency", cyc - it.t0, it.lat);
          prev_res  = result_o;
          chk_after = 1;
        end
      end
    end
  end

  // Driver: one conversion, optional start pulse during the search.
  task automatic convert(input logic [RES-1:0] v, input int a, input int s, input bit poke);
    int   ae;
    int   se;
    exp_t it;
    ae = (a == 0) ? 1 : a;
    se = (s == 0) ? 1 : s;
    vin          = v;
    acq_len_i    = CNT_W'(a);
    settle_len_i = CNT_W'(s);
    settle_eff   = se;
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    it.code = v;
    it.t0   = cyc;
    it.lat  = ae + RES * se;
    exp_q.push_back(it);
    check(sw_in_trk_o && sw_node_trk_o, "R2 track during acquisition",
          int'(sw_in_trk_o), 1);
    check(dac_o == '0, "R4 dac zero while tracking", int'(dac_o), 0);
    repeat (ae) @(negedge clk);
    check(!sw_in_trk_o && !sw_node_trk_o, "R2 R3 hold after acquisition",
          int'(sw_in_trk_o), 0);
    check(dac_o == 12'h800, "R5 first code is MSB", int'(dac_o), 'h800);
    check(result_o == prev_res, "R9 result held during conversion",
          int'(result_o), int'(prev_res));
    if (poke) begin
      start_i = 1'b1;  // R8: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(sw_in_trk_o && (dac_o == '0), "R2 R4 back to track with zero code",
          int'(dac_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [RES-1:0] lcg;
    repeat (3) @(negedge clk);
    check(sw_in_trk_o && sw_node_trk_o, "R1 switches track in reset", int'(sw_in_trk_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac_o == '0, "R1 dac zero after reset", int'(dac_o), 0);
    check(result_o == '0, "R1 result zero after reset", int'(result_o), 0);
    check(!done_o, "R1 done low after reset", int'(done_o), 0);
    check(sw_in_trk_o && sw_node_trk_o, "R1 R2 track after reset", int'(sw_node_trk_o), 1);

    convert(12'h000, 4, 2, 0);
    convert(12'hFFF, 1, 1, 0);
    convert(12'h800, 0, 3, 0);   // R3: zero acquisition acts as one
    convert(12'h7FF, 5, 0, 0);   // R5: zero settle acts as one
    convert(12'h555, 3, 4, 1);   // R8: start poked mid-search
    convert(12'hAAA, 2, 2, 1);
    convert(12'h001, 1, 5, 0);   // R10: long settle with disturbed comparator
    convert(12'hFFE, 7, 1, 0);
    lcg = 12'h3A7;
    for (int k = 0; k < 6; k++) begin
      lcg = lcg * 12'd1103 + 12'd2531;
      convert(lcg, (k % 4), 1 + (k % 3), k[0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule